// File: doc/BRIEF.md
# Per-Lane Drive Level Clamp Encoder

This block turns the drive adjustment requests that a serial display sink reports for each lane into legal transmitter drive levels. It produces two things from them: the per-lane setting bytes that go back to the sink, and the 2-bit level controls for the PHY. The requests arrive as packed status bytes, with one 4-bit nibble per lane and two lanes per byte. A separate byte carries the post-cursor2 requests, two bits per lane.

A training controller applies a one-cycle `commit` strobe. On that edge the block clamps each active lane's request and latches the results. Swing and pre-emphasis may not sum above 3, and pre-emphasis and post-cursor2 are each capped at 3. Each field that hits its ceiling gets a max-reached flag. One cycle later the block raises a write strobe for the four lane-setting bytes. It raises a second strobe for the two post-cursor2 bytes only when post-cursor2 is enabled. Lanes at or beyond the active lane count keep their previous settings.

Top module: `lane_drive_top`

## Requirements
- R1: The request nibble for lane i comes from status byte i>>1 (byte k at `adj_status[8k+7:8k]`), low nibble for even i and high nibble for odd i. Within the nibble, bits [1:0] request swing and bits [3:2] request pre-emphasis.
- R2: After any commit, every lane's swing level plus pre-emphasis level is at most 3.
- R3: A pre-emphasis request of 3 sets the lane's pre-emphasis to 3 with its max flag and forces swing to 0 with no swing flag. The setting byte is then 0x38.
- R4: Otherwise, a swing request at or above 3 minus the pre-emphasis request sets swing to that limit and sets the swing max flag. Below the limit, the request passes unchanged and no flag is set.
- R5: The lane setting byte for lane i sits at `lane_set[8i+7:8i]`. Bits [1:0] hold swing, bit 2 is the swing max flag, bits [4:3] hold pre-emphasis, bit 5 is the pre-emphasis max flag, and bits [7:6] are zero.
- R6: A commit leaves every lane at index ≥ `lane_count` unchanged, both its setting byte and its post-cursor2 nibble. With `lane_count` 0, nothing changes.
- R7: `wr_valid` is high for exactly the cycle after a commit. `pc2_wr_valid` is high in that same cycle only if `pc2_en` was high at the commit.
- R8: `phy_swing`, `phy_preemph` and `phy_pc2` (2 bits per lane, lane i at bits [2i+1:2i]) carry the level values without flags. They change on the same edge as the setting bytes.
- R9: The post-cursor2 request for lane i is `pc2_req[2i+1:2i]`. A request of 3 gives the nibble 0x7 (level 3 with its flag at bit 2); any lower request gives the level unchanged. The nibble for lane i goes to byte i>>1 of `pc2_set`, in the low nibble for even i and the high nibble for odd i.
- R10: Reset clears all setting bytes, post-cursor2 bytes, PHY levels and both strobes to zero.
- R11: Without a commit, all outputs other than the strobes hold their values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit | input | 1 | Latch clamped settings this edge |
| lane_count | input | 3 | Number of active lanes, 0 to 4 |
| pc2_en | input | 1 | Post-cursor2 bytes are to be written |
| adj_status | input | 16 | Packed per-lane swing/pre-emphasis requests |
| pc2_req | input | 8 | Packed per-lane post-cursor2 requests |
| lane_set | output | 32 | Four lane setting bytes |
| pc2_set | output | 16 | Two packed post-cursor2 bytes |
| phy_swing | output | 8 | Per-lane swing level to PHY |
| phy_preemph | output | 8 | Per-lane pre-emphasis level to PHY |
| phy_pc2 | output | 8 | Per-lane post-cursor2 level to PHY |
| wr_valid | output | 1 | Setting bytes ready for burst write |
| pc2_wr_valid | output | 1 | Post-cursor2 bytes ready for write |

## Verification
The bench drives a set of request patterns, each built to separate one behaviour:
- Full four-lane commits that give every lane a different nibble. These separate the three clamp branches: the pre-emphasis ceiling, the swing limit and the pass-through case. They also show any swapped nibble or byte order.
- Requests that sit exactly on the sum limit and one step below it. These separate a `>=` comparison from a `>` comparison.
- Commits with lane counts of 2, 1 and 0, sent with deliberately saturating requests on the inactive lanes. These show whether inactive lanes are masked.
- Alternating `pc2_en` across commits. This shows whether the post-cursor2 write strobe is gated.
- An idle stretch with changing inputs and a mid-run reset. These confirm that state holds without a commit and clears on reset.

// File: rtl/lane_drive_pkg.sv
package lane_drive_pkg;
  localparam int LVL_W     = 2;
  localparam int LEVEL_MAX = 3;
  localparam int REQ_W     = 4;
  localparam int BYTE_W    = 8;
  localparam int NIB_W     = 4;

  typedef struct packed {
    logic             maxed;
    logic [LVL_W-1:0] lvl;
  } level_t;
endpackage

// File: rtl/lane_drive_clamp.sv
module lane_drive_clamp
  import lane_drive_pkg::*;
(
  input  logic [REQ_W-1:0]  req,
  output logic [BYTE_W-1:0] set_byte,
  output logic [LVL_W-1:0]  swing,
  output logic [LVL_W-1:0]  preemph
);
  logic [LVL_W-1:0] req_sw;
  logic [LVL_W-1:0] req_pe;
  logic [LVL_W-1:0] sw_limit;
  level_t           sw_f;
  level_t           pe_f;

  assign req_sw   = req[LVL_W-1:0];
  assign req_pe   = req[2*LVL_W-1:LVL_W];
  assign sw_limit = LVL_W'(LEVEL_MAX) - req_pe;

  always_comb begin
    if (req_pe >= LVL_W'(LEVEL_MAX)) begin
      pe_f = '{maxed: 1'b1, lvl: LVL_W'(LEVEL_MAX)};
      sw_f = '{maxed: 1'b0, lvl: '0};
    end else begin
      pe_f = '{maxed: 1'b0, lvl: req_pe};
      if (req_sw >= sw_limit) begin
        sw_f = '{maxed: 1'b1, lvl: sw_limit};
      end else begin
        sw_f = '{maxed: 1'b0, lvl: req_sw};
      end
    end
  end

  assign set_byte = {2'b00, pe_f, sw_f};
  assign swing    = sw_f.lvl;
  assign preemph  = pe_f.lvl;
endmodule

// File: rtl/lane_pc2_clamp.sv
module lane_pc2_clamp
  import lane_drive_pkg::*;
(
  input  logic [LVL_W-1:0] req,
  output logic [NIB_W-1:0] nib,
  output logic [LVL_W-1:0] lvl
);
  level_t f;

  always_comb begin
    if (req >= LVL_W'(LEVEL_MAX)) begin
      f = '{maxed: 1'b1, lvl: LVL_W'(LEVEL_MAX)};
    end else begin
      f = '{maxed: 1'b0, lvl: req};
    end
  end

  assign nib = {1'b0, f};
  assign lvl = f.lvl;
endmodule

// File: rtl/lane_drive_top.sv
module lane_drive_top
  import lane_drive_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             commit,
  input  logic [$clog2(LANES+1)-1:0]       lane_count,
  input  logic                             pc2_en,
  input  logic [(LANES/2)*BYTE_W-1:0]      adj_status,
  input  logic [LANES*LVL_W-1:0]           pc2_req,
  output logic [LANES*BYTE_W-1:0]          lane_set,
  output logic [(LANES/2)*BYTE_W-1:0]      pc2_set,
  output logic [LANES*LVL_W-1:0]           phy_swing,
  output logic [LANES*LVL_W-1:0]           phy_preemph,
  output logic [LANES*LVL_W-1:0]           phy_pc2,
  output logic                             wr_valid,
  output logic                             pc2_wr_valid
);
  localparam int CNT_W    = $clog2(LANES+1);
  localparam int SET_W    = LANES*BYTE_W;
  localparam int PC2SET_W = (LANES/2)*BYTE_W;
  localparam int PHY_W    = LANES*LVL_W;

  logic [LANES-1:0]    lane_active;
  logic [SET_W-1:0]    lane_set_d;
  logic [PC2SET_W-1:0] pc2_set_d;
  logic [PHY_W-1:0]    swing_d;
  logic [PHY_W-1:0]    preemph_d;
  logic [PHY_W-1:0]    pc2_d;

  logic [SET_W-1:0]    cl_byte;
  logic [PHY_W-1:0]    cl_swing;
  logic [PHY_W-1:0]    cl_pre;
  logic [LANES*NIB_W-1:0] cl_pc2nib;
  logic [PHY_W-1:0]    cl_pc2;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int NIB_POS = BYTE_W*(i/2) + NIB_W*(i%2);

    lane_drive_clamp u_clamp (
      .req      (adj_status[NIB_POS +: NIB_W]),
      .set_byte (cl_byte[i*BYTE_W +: BYTE_W]),
      .swing    (cl_swing[i*LVL_W +: LVL_W]),
      .preemph  (cl_pre[i*LVL_W +: LVL_W])
    );

    lane_pc2_clamp u_pc2 (
      .req (pc2_req[i*LVL_W +: LVL_W]),
      .nib (cl_pc2nib[i*NIB_W +: NIB_W]),
      .lvl (cl_pc2[i*LVL_W +: LVL_W])
    );

    assign lane_active[i] = commit && (CNT_W'(i) < lane_count);
  end

  // next-state selection per lane
  always_comb begin
    lane_set_d = lane_set;
    pc2_set_d  = pc2_set;
    swing_d    = phy_swing;
    preemph_d  = phy_preemph;
    pc2_d      = phy_pc2;
    for (int i = 0; i < LANES; i++) begin
      if (lane_active[i]) begin
        lane_set_d[i*BYTE_W +: BYTE_W] = cl_byte[i*BYTE_W +: BYTE_W];
        pc2_set_d[BYTE_W*(i/2) + NIB_W*(i%2) +: NIB_W] = cl_pc2nib[i*NIB_W +: NIB_W];
        swing_d[i*LVL_W +: LVL_W]   = cl_swing[i*LVL_W +: LVL_W];
        preemph_d[i*LVL_W +: LVL_W] = cl_pre[i*LVL_W +: LVL_W];
        pc2_d[i*LVL_W +: LVL_W]     = cl_pc2[i*LVL_W +: LVL_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_set    <= '0;
      pc2_set     <= '0;
      phy_swing   <= '0;
      phy_preemph <= '0;
      phy_pc2     <= '0;
    end else if (commit) begin
      lane_set    <= lane_set_d;
      pc2_set     <= pc2_set_d;
      phy_swing   <= swing_d;
      phy_preemph <= preemph_d;
      phy_pc2     <= pc2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid     <= 1'b0;
      pc2_wr_valid <= 1'b0;
    end else begin
      wr_valid     <= commit;
      pc2_wr_valid <= commit && pc2_en;
    end
  end
endmodule

// File: rtl/lane_drive_checker.sv
module lane_drive_checker
  import lane_drive_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        commit,
  input logic                        pc2_en,
  input logic [LANES*BYTE_W-1:0]     lane_set,
  input logic [(LANES/2)*BYTE_W-1:0] pc2_set,
  input logic [LANES*LVL_W-1:0]      phy_swing,
  input logic [LANES*LVL_W-1:0]      phy_preemph,
  input logic [LANES*LVL_W-1:0]      phy_pc2,
  input logic                        wr_valid,
  input logic                        pc2_wr_valid
);
  p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> wr_valid);
  p_pc2_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc2_wr_valid |-> wr_valid);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(lane_set) && $stable(pc2_set) && $stable(phy_swing)));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    p_sum_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, phy_swing[i*LVL_W +: LVL_W]} + {1'b0, phy_preemph[i*LVL_W +: LVL_W]}) <= 3'd3);
    p_pe_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lane_set[i*BYTE_W + 5] |-> (lane_set[i*BYTE_W +: 3] == 3'd0));
    p_phy_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_swing[i*LVL_W +: LVL_W] == lane_set[i*BYTE_W +: 2]) &&
      (phy_preemph[i*LVL_W +: LVL_W] == lane_set[i*BYTE_W + 3 +: 2]));
    p_pc2_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      phy_pc2[i*LVL_W +: LVL_W] == pc2_set[BYTE_W*(i/2) + NIB_W*(i%2) +: LVL_W]);
  end
endmodule

bind lane_drive_top lane_drive_checker #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .commit       (commit),
  .pc2_en       (pc2_en),
  .lane_set     (lane_set),
  .pc2_set      (pc2_set),
  .phy_swing    (phy_swing),
  .phy_preemph  (phy_preemph),
  .phy_pc2      (phy_pc2),
  .wr_valid     (wr_valid),
  .pc2_wr_valid (pc2_wr_valid)
);

// File: tb/lane_drive_top_test.sv
module lane_drive_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  typedef struct packed {
    logic [2:0]  cnt;
    logic        pen;
    logic [15:0] adj;
    logic [7:0]  pc2r;
    logic [31:0] exp_set;
    logic [15:0] exp_pc2;
  } vec_t;

  // R1 R3 R4 R5 R6 R9 vectors; state carries across rows
  localparam vec_t VECS [NVEC] = '{
    '{3'd4, 1'b1, 16'hF365, 8'hE4, 32'h38070E09, 16'h7210},
    '{3'd4, 1'b0, 16'hA08B, 8'h00, 32'h15001015, 16'h0000},
    '{3'd2, 1'b1, 16'hFF44, 8'hFF, 32'h15000808, 16'h0077},
    '{3'd1, 1'b0, 16'h0007, 8'h01, 32'h1500080E, 16'h0071},
    '{3'd0, 1'b1, 16'hFFFF, 8'hFF, 32'h1500080E, 16'h0071},
    '{3'd3, 1'b1, 16'hFC02, 8'hE2, 32'h15380002, 16'h0202}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        commit;
  logic [2:0]  lane_count;
  logic        pc2_en;
  logic [15:0] adj_status;
  logic [7:0]  pc2_req;
  logic [31:0] lane_set;
  logic [15:0] pc2_set;
  logic [7:0]  phy_swing, phy_preemph, phy_pc2;
  logic        wr_valid, pc2_wr_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_drive_top #(.LANES(4)) uut (
    .clk(clk), .rst_n(rst_n), .commit(commit), .lane_count(lane_count),
    .pc2_en(pc2_en), .adj_status(adj_status), .pc2_req(pc2_req),
    .lane_set(lane_set), .pc2_set(pc2_set), .phy_swing(phy_swing),
    .phy_preemph(phy_preemph), .phy_pc2(phy_pc2), .wr_valid(wr_valid),
    .pc2_wr_valid(pc2_wr_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] phy_from(input logic [31:0] s, input int lsb);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) r[2*i +: 2] = s[8*i + lsb +: 2];
    return r;
  endfunction

  function automatic logic [7:0] pc2_from(input logic [15:0] p);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) r[2*i +: 2] = p[8*(i/2) + 4*(i%2) +: 2];
    return r;
  endfunction

  initial begin
    rst_n = 1'b0; commit = 1'b0; lane_count = '0; pc2_en = 1'b0;
    adj_status = '0; pc2_req = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 lane_set", lane_set, 32'h0);
    check("R10 pc2_set", {16'h0, pc2_set}, 32'h0);
    check("R10 phy", {8'h0, phy_swing, phy_preemph, phy_pc2}, 32'h0);
    check("R10 strobes", {30'h0, wr_valid, pc2_wr_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      lane_count = VECS[v].cnt; pc2_en = VECS[v].pen;
      adj_status = VECS[v].adj; pc2_req = VECS[v].pc2r; commit = 1'b1;
      @(negedge clk);
      commit = 1'b0;
      check("R3 R4 R5 R6 lane_set", lane_set, VECS[v].exp_set);
      check("R9 R6 pc2_set", {16'h0, pc2_set}, {16'h0, VECS[v].exp_pc2});
      check("R8 phy_swing", {24'h0, phy_swing}, {24'h0, phy_from(VECS[v].exp_set, 0)});
      check("R8 phy_preemph", {24'h0, phy_preemph}, {24'h0, phy_from(VECS[v].exp_set, 3)});
      check("R8 phy_pc2", {24'h0, phy_pc2}, {24'h0, pc2_from(VECS[v].exp_pc2)});
      check("R7 wr_valid", {31'h0, wr_valid}, 32'h1);
      check("R7 pc2_wr_valid", {31'h0, pc2_wr_valid}, {31'h0, VECS[v].pen});
      @(negedge clk);
      check("R7 strobe drop", {30'h0, wr_valid, pc2_wr_valid}, 32'h0);
    end

    // R11: inputs change without commit; nothing moves
    adj_status = 16'h3333; pc2_req = 8'hFF; lane_count = 3'd4; pc2_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 hold lane_set", lane_set, 32'h15380002);
    check("R11 hold pc2_set", {16'h0, pc2_set}, 32'h0202);
    check("R11 no strobe", {30'h0, wr_valid, pc2_wr_valid}, 32'h0);

    // R2 R4 boundary: each lane exactly at and below limit
    // lanes: 0x1 (pe0 sw1), 0x9 (pe2 sw1 -> at limit 1), 0x4 (pe1 sw0), 0x2 (pe0 sw2)
    adj_status = 16'h2491; pc2_req = 8'h00; commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    check("R4 boundary lane_set", lane_set, 32'h02081501);
    check("R2 sum swing", {24'h0, phy_swing}, {24'h0, 8'b10_00_01_01});
    check("R2 sum preemph", {24'h0, phy_preemph}, {24'h0, 8'b00_01_10_00});

    // R10 mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 mid reset lane_set", lane_set, 32'h0);
    check("R10 mid reset phy", {8'h0, phy_swing, phy_preemph, phy_pc2}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule